// File: doc/BRIEF.md
# SDRAM Refresh Request Timer

This block paces refresh work for an SDRAM controller. A two-bit rate selector picks one of three refresh intervals or turns refresh off. The controller clock frequency is a parameter, and the block converts the chosen interval into a cycle count when it is elaborated. Each time an interval runs out, the block raises a refresh request. The request stays up until the command sequencer acknowledges it with a one-cycle pulse.

If intervals keep running out while a request is still waiting, the block counts the owed refreshes in a small saturating backlog counter. The sequencer works off this backlog one acknowledge at a time. The total refresh debt is the request bit plus the backlog. Selecting the off setting drops the request, empties the backlog and parks the interval counter.

Top module: `rfsh_req_timer`

## Requirements
- R1: After a synchronous active-low reset, `refresh_req` is 0 and `backlog` is 0.
- R2: While `rate_sel` is 00, `refresh_req` never rises and `backlog` stays 0.
- R3: The interval length in cycles is floor(T × CLK_MHZ / 10), where T is 78 for `rate_sel` 01 (7.8 µs), 156 for 10 (15.6 µs) and 1250 for 11 (125 µs). With a steady non-zero `rate_sel`, successive interval expiries are exactly that many cycles apart.
- R4: CLK_MHZ may only be 66, 100 or 133. Any other value stops elaboration.
- R5: A new non-zero `rate_sel` value restarts the interval. If the first rising edge that sees the new value is edge k, the first request from it is visible after edge k+L, where L is the new interval length.
- R6: Once raised, `refresh_req` stays high until an acknowledge is taken.
- R7: An acknowledge taken while `backlog` is 0 and no interval expires clears `refresh_req` at the next edge. An acknowledge while `refresh_req` is low has no effect.
- R8: An interval that expires while `refresh_req` is high and no acknowledge is present adds one to `backlog`. The backlog saturates at 7.
- R9: An acknowledge taken while `backlog` is non-zero lowers `backlog` by one and leaves `refresh_req` high.
- R10: An expiry in the same cycle as an acknowledge of an outstanding request leaves `refresh_req` high and `backlog` unchanged.
- R11: Changing `rate_sel` to 00 clears `refresh_req` and `backlog` at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, CLK_MHZ |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 2 | Interval selector: 00 off, 01 7.8 µs, 10 15.6 µs, 11 125 µs |
| refresh_ack | input | 1 | One refresh carried out by the sequencer |
| refresh_req | output | 1 | A refresh is owed |
| backlog | output | 3 | Owed refreshes beyond the one being requested, saturating at 7 |

## Verification
The bound checker watches the per-cycle rules on every cycle. A request rises only in the cycle after an expiry. It holds without an acknowledge. A backlog always comes with a request. The backlog moves by at most one per cycle. The off setting empties everything on the next edge, and a stray acknowledge cannot raise or change anything. Only the bench scenarios can show the absolute interval lengths for each selector value, the restart on a rate change, saturation after many missed intervals, and the draining order. Those depend on counts of thousands of cycles and on aligning the acknowledge with an expiry edge.

// File: rtl/rfsh_pkg.sv
// Package: shared constants and the interval-to-cycles conversion for the
// refresh request timer. Assumes the clock frequency is given in whole MHz.
package rfsh_pkg;

    // Selector encodings; the numeric values are part of the register contract.
    localparam logic [1:0] RATE_OFF  = 2'b00;
    localparam logic [1:0] RATE_FAST = 2'b01;
    localparam logic [1:0] RATE_MID  = 2'b10;
    localparam logic [1:0] RATE_SLOW = 2'b11;

    // Interval length in tenths of a microsecond for each selector value.
    function automatic int unsigned interval_tenths_us(input logic [1:0] sel);
        case (sel)
            RATE_FAST: return 78;
            RATE_MID:  return 156;
            RATE_SLOW: return 1250;
            default:   return 0;
        endcase
    endfunction

    // Cycles per interval, rounded down so a refresh is never late.
    function automatic int unsigned interval_cycles(input logic [1:0] sel,
                                                    input int unsigned mhz);
        return (interval_tenths_us(sel) * mhz) / 10;
    endfunction

    // True for the supported controller clock frequencies.
    function automatic bit mhz_supported(input int unsigned mhz);
        return (mhz == 66) || (mhz == 100) || (mhz == 133);
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Module: interval counter. Turns the selector into a terminal count and
// emits a one-cycle expiry pulse every interval. Assumes the selector is
// synchronous to clk. A change of selector restarts the count from zero on
// the next edge; the off setting holds the count at zero.
module rfsh_interval_timer
    import rfsh_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 100,
    parameter int unsigned CNT_W   = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    output logic       expire
);

    localparam int unsigned NUM_SEL = 4;

    logic [CNT_W-1:0] term_tab [NUM_SEL];
    logic [CNT_W-1:0] term_cur;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       sel_q;
    logic             sel_moved;
    logic             running;

    // One terminal count per selector value, fixed at elaboration.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_term
        localparam int unsigned LEN = interval_cycles(2'(g), CLK_MHZ);
        if (LEN == 0) begin : g_off
            assign term_tab[g] = '0;
        end else begin : g_on
            assign term_tab[g] = CNT_W'(LEN - 1);
        end
    end

    // Pick the terminal count for the live selector and classify the cycle.
    always_comb begin
        term_cur  = term_tab[rate_sel];
        sel_moved = (rate_sel != sel_q);
        running   = (rate_sel != RATE_OFF) && !sel_moved;
        expire    = running && (cnt_q == term_cur);
    end

    // Track the selector and advance, wrap or restart the cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= RATE_OFF;
            cnt_q <= '0;
        end else begin
            sel_q <= rate_sel;
            if (!running || expire) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rfsh_req_tracker.sv
// Module: request and backlog bookkeeping. Holds the refresh request until
// acknowledged and counts expiries that arrive while a request is waiting.
// Assumes the acknowledge is sampled once per cycle; a multi-cycle
// acknowledge counts as one acknowledge per cycle.
module rfsh_req_tracker #(
    parameter int unsigned BACKLOG_MAX = 7,
    parameter int unsigned BACKLOG_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 expire,
    input  logic                 ack,
    output logic                 req,
    output logic [BACKLOG_W-1:0] owed
);

    localparam logic [BACKLOG_W-1:0] OWED_TOP = BACKLOG_W'(BACKLOG_MAX);

    logic                 req_q;
    logic [BACKLOG_W-1:0] owed_q;
    logic                 ack_taken;
    logic                 owed_full;

    // Only an acknowledge against an outstanding request counts.
    always_comb begin
        ack_taken = ack && req_q;
        owed_full = (owed_q == OWED_TOP);
    end

    // Update the request flag and the saturating backlog.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            req_q  <= 1'b0;
            owed_q <= '0;
        end else if (expire && !req_q) begin
            req_q <= 1'b1;
        end else if (expire && !ack_taken) begin
            if (!owed_full) begin
                owed_q <= owed_q + 1'b1;
            end
        end else if (!expire && ack_taken) begin
            if (owed_q != '0) begin
                owed_q <= owed_q - 1'b1;
            end else begin
                req_q <= 1'b0;
            end
        end
    end

    assign req  = req_q;
    assign owed = owed_q;

endmodule

// File: rtl/rfsh_req_timer.sv
// Module: top of the refresh request timer. Joins the interval counter and
// the request tracker. Assumes CLK_MHZ is one of the supported controller
// clock rates and that rate_sel and refresh_ack are synchronous to clk.
module rfsh_req_timer
    import rfsh_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned BACKLOG_MAX = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel,
    input  logic       refresh_ack,
    output logic       refresh_req,
    output logic [2:0] backlog
);

    localparam int unsigned LONGEST   = interval_cycles(RATE_SLOW, CLK_MHZ);
    localparam int unsigned CNT_W     = $clog2(LONGEST + 1);
    localparam int unsigned BACKLOG_W = 3;

    // Refuse to build for an unsupported clock rate.
    if (!mhz_supported(CLK_MHZ)) begin : g_bad_clk
        $error("rfsh_req_timer: CLK_MHZ must be 66, 100 or 133");
    end

    logic disabled;
    logic expire;

    // The off setting flushes the request state.
    always_comb disabled = (rate_sel == RATE_OFF);

    rfsh_interval_timer #(
        .CLK_MHZ (CLK_MHZ),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .expire   (expire)
    );

    rfsh_req_tracker #(
        .BACKLOG_MAX (BACKLOG_MAX),
        .BACKLOG_W   (BACKLOG_W)
    ) u_tracker (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (disabled),
        .expire (expire),
        .ack    (refresh_ack),
        .req    (refresh_req),
        .owed   (backlog)
    );

endmodule

// File: rtl/rfsh_req_timer_chk.sv
// Module: protocol checker for the refresh request timer, bound to the top.
// Watches ports plus the expiry pulse passed from the interval counter to
// the tracker.
module rfsh_req_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rate_sel,
    input logic       refresh_ack,
    input logic       refresh_req,
    input logic [2:0] backlog,
    input logic       expire
);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req && !refresh_ack && rate_sel != 2'b00) |=> refresh_req);

    // R5
    req_rise_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_req) |-> $past(expire));

    // R11
    off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b00) |=> (!refresh_req && backlog == 3'd0));

    // R8
    backlog_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (backlog != 3'd0) |-> refresh_req);

    // R8
    backlog_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != 2'b00) |=>
            ({1'b0, backlog} == {1'b0, $past(backlog)} + 4'd1) ||
            ({1'b0, backlog} + 4'd1 == {1'b0, $past(backlog)}) ||
            (backlog == $past(backlog)));

    // R7
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_req && !expire) |=> !refresh_req);

    // R2
    off_no_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 2'b00) |-> !expire);

endmodule

bind rfsh_req_timer rfsh_req_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rate_sel    (rate_sel),
    .refresh_ack (refresh_ack),
    .refresh_req (refresh_req),
    .backlog     (backlog),
    .expire      (expire)
);

// File: tb/rfsh_req_timer_bench.sv
// Bench: directed scenarios for the refresh request timer at CLK_MHZ = 100.
module rfsh_req_timer_bench;

    localparam int MHZ  = 100;
    localparam int LEN1 = 78 * MHZ / 10;
    localparam int LEN2 = 156 * MHZ / 10;
    localparam int LEN3 = 1250 * MHZ / 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       refresh_ack = 1'b0;
    logic       refresh_req;
    logic [2:0] backlog;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rfsh_req_timer #(.CLK_MHZ(MHZ)) u_rfsh_req_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_sel    (rate_sel),
        .refresh_ack (refresh_ack),
        .refresh_req (refresh_req),
        .backlog     (backlog)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count negedges until the request is seen high.
    task automatic wait_req(output int n);
        n = 0;
        while (!refresh_req && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        step(3);
        check("R1 req after reset", int'(refresh_req), 0);
        check("R1 backlog after reset", int'(backlog), 0);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_fast_period();
        int n;
        int t0;
        rate_sel = 2'b01;
        wait_req(n);
        check("R5 first request after select 01", n, LEN1 + 1);
        t0 = cyc;
        refresh_ack = 1'b1;
        step(1);
        refresh_ack = 1'b0;
        check("R7 ack clears request", int'(refresh_req), 0);
        wait_req(n);
        check("R3 interval for 01 (R4 at 100 MHz)", cyc - t0, LEN1);
    endtask

    task automatic t_backlog();
        check("R6 request held", int'(refresh_req), 1);
        step(3 * LEN1);
        check("R8 backlog after 3 missed", int'(backlog), 3);
        check("R6 request still held", int'(refresh_req), 1);
        step(6 * LEN1);
        check("R8 backlog saturates", int'(backlog), 7);
        step(LEN1);
        check("R8 backlog stays at limit", int'(backlog), 7);
        refresh_ack = 1'b1;
        step(1);
        check("R9 backlog after one ack", int'(backlog), 6);
        check("R9 request kept", int'(refresh_req), 1);
        step(6);
        check("R9 backlog drained", int'(backlog), 0);
        check("R9 request kept after drain", int'(refresh_req), 1);
        step(1);
        refresh_ack = 1'b0;
        check("R7 final ack clears", int'(refresh_req), 0);
    endtask

    task automatic t_coincide();
        int n;
        wait_req(n);
        step(LEN1 - 1);
        refresh_ack = 1'b1;
        step(1);
        refresh_ack = 1'b0;
        check("R10 request with ack on expiry", int'(refresh_req), 1);
        check("R10 backlog with ack on expiry", int'(backlog), 0);
        refresh_ack = 1'b1;
        step(1);
        check("R7 request cleared", int'(refresh_req), 0);
        step(5);
        refresh_ack = 1'b0;
        check("R7 stray ack leaves request low", int'(refresh_req), 0);
        check("R7 stray ack leaves backlog", int'(backlog), 0);
    endtask

    task automatic t_rate_change();
        int n;
        step(100);
        rate_sel = 2'b10;
        wait_req(n);
        check("R5 restart on change to 10 (R3)", n, LEN2 + 1);
        step(LEN2 / 2);
        rate_sel = 2'b11;
        wait_req(n);
        check("R5 request held across change", n, 0);
        step(1);
        refresh_ack = 1'b1;
        step(1);
        refresh_ack = 1'b0;
        wait_req(n);
        check("R3 interval for 11", n, LEN3 - 1);
    endtask

    task automatic t_disable();
        int rises = 0;
        step(2 * LEN3 / 1000 + 1);
        rate_sel = 2'b01;
        step(3 * LEN1 + 2);
        check("R8 backlog built before off", int'(backlog), 3);
        rate_sel = 2'b00;
        step(1);
        check("R11 off clears request", int'(refresh_req), 0);
        check("R11 off clears backlog", int'(backlog), 0);
        for (int i = 0; i < LEN3 + 500; i++) begin
            if (i == 10) refresh_ack = 1'b1;
            if (i == 12) refresh_ack = 1'b0;
            @(negedge clk);
            if (refresh_req || backlog != 3'd0) rises++;
        end
        check("R2 no request while off", rises, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fast_period();
        t_backlog();
        t_coincide();
        t_rate_change();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule